// File: doc/BRIEF.md
# Always-On Subclock Time-Base Prescaler

This block is a small free-running time base fed by the low-frequency subclock, which runs at 32.768 kHz or 38.4 kHz. An internal phase stage makes an advance enable once every four subclock cycles. A 5-bit up-counter advances on that enable, so each counter step lasts four subclock periods. A watch-style timer taps the count bits to get its periodic intervals. It also uses a one-cycle strobe for each carry out of a counter bit, and a separate strobe for the full wrap.

The block has no mode or stop input, so it keeps counting through every low-power state of the chip. Software can restart the time base only through an ordinary control-register write. The clear happens when both designated control bits in the written byte are one. The clear resets the counter and also the divide-by-four phase, so the interval after a clear is a full, exact step.

Top module: `subclk_timebase`

## Requirements
- R1: While `rst` is high at a rising edge, the count, `ovf_stb`, every `tap_stb` bit and the divide-by-four phase all become zero.
- R2: After `rst` falls, the count first advances on the 4th rising edge. After that it advances by exactly one on every 4th rising edge and holds its value on the other edges.
- R3: When the count advances from 31, it becomes 0 and `ovf_stb` is high for exactly that one cycle. `ovf_stb` is low at all other times.
- R4: `tap_stb[i]` is high for one cycle after an advance in which count bits i down to 0 were all one before the advance, which means a carry out of bit i. `tap_stb[4]` therefore coincides with the wrap.
- R5: A rising edge with `wr_en` high and `wr_data` bits 3 and 2 both one clears the count, the strobes and the phase on that edge. The next advance comes on the 4th edge after it.
- R6: A write where bit 3 or bit 2 of `wr_data` is zero leaves the count and the advance phase unchanged, whatever the other bits are.
- R7: When a clearing write falls on the same edge as an advance, the clear wins. This includes an advance from 31: the count reads 0 and no strobe is raised.
- R8: Counting never pauses. There is no enable or mode input, and over any 200 edges without a clear the count advances exactly 50 times, modulo 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Raw subclock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_data | input | 8 | Byte being written; bits 3 and 2 request the clear |
| count | output | 5 | Current time-base count |
| ovf_stb | output | 1 | One-cycle strobe on wrap from 31 to 0 |
| tap_stb | output | 5 | One-cycle carry strobe for each count bit |

## Verification
A wrong divide-by-four phase does not change the count value right away. It shows up within at most four edges, when an advance lands on the wrong edge or a post-clear interval is not exactly four. A counter or carry fault shows at the ports on the first advance that touches it. A bad tap chain, however, can hide until a wrap, which is up to 128 edges away. The bench therefore compares every output on every cycle, runs through a complete wrap, and places clears and ignored writes on each phase of the divider.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  localparam int unsigned DEF_CNT_W  = 5;
  localparam int unsigned DEF_DIV    = 4;
  localparam int unsigned DEF_CTRL_W = 8;
  localparam int unsigned DEF_CLR_HI = 3;
  localparam int unsigned DEF_CLR_LO = 2;

  // Mask with the two clear-request bits set
  function automatic logic [DEF_CTRL_W-1:0] clr_mask(input int unsigned hi, input int unsigned lo);
    logic [DEF_CTRL_W-1:0] m;
    m = '0;
    m[hi] = 1'b1;
    m[lo] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/tbase_clear_detect.sv
module tbase_clear_detect #(
  parameter int unsigned CTRL_W = tbase_pkg::DEF_CTRL_W,
  parameter int unsigned CLR_HI = tbase_pkg::DEF_CLR_HI,
  parameter int unsigned CLR_LO = tbase_pkg::DEF_CLR_LO
) (
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic              clr_hit
);
  localparam logic [CTRL_W-1:0] MASK = CTRL_W'(tbase_pkg::clr_mask(CLR_HI, CLR_LO));

  // Both request bits must be one; other bits are don't-care
  always_comb begin
    clr_hit = wr_en && ((wr_data & MASK) == MASK);
  end
endmodule

// File: rtl/tbase_phase_div.sv
module tbase_phase_div #(
  parameter int unsigned DIV = tbase_pkg::DEF_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_clr,
  output logic tick
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);
  localparam logic [DW-1:0] ONE  = DW'(1);

  logic [DW-1:0] phase;

  always_comb begin
    tick = (phase == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || sync_clr) begin
      phase <= '0;
    end else if (tick) begin
      phase <= '0;
    end else begin
      phase <= phase + ONE;
    end
  end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
  parameter int unsigned CNT_W = tbase_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_clr,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             ovf_stb,
  output logic [CNT_W-1:0] tap_stb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] carry;

  // Ripple of all-ones detection, one stage per bit
  generate
    for (genvar i = 0; i < CNT_W; i++) begin : g_carry
      if (i == 0) begin : g_first
        assign carry[i] = count[0];
      end else begin : g_next
        assign carry[i] = carry[i-1] & count[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || sync_clr) begin
      count   <= '0;
      ovf_stb <= 1'b0;
      tap_stb <= '0;
    end else if (tick) begin
      count   <= count + ONE;
      ovf_stb <= carry[CNT_W-1];
      tap_stb <= carry;
    end else begin
      ovf_stb <= 1'b0;
      tap_stb <= '0;
    end
  end
endmodule

// File: rtl/subclk_timebase.sv
module subclk_timebase #(
  parameter int unsigned CNT_W  = tbase_pkg::DEF_CNT_W,
  parameter int unsigned DIV    = tbase_pkg::DEF_DIV,
  parameter int unsigned CTRL_W = tbase_pkg::DEF_CTRL_W,
  parameter int unsigned CLR_HI = tbase_pkg::DEF_CLR_HI,
  parameter int unsigned CLR_LO = tbase_pkg::DEF_CLR_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_stb,
  output logic [CNT_W-1:0]  tap_stb
);
  logic clr_hit;
  logic tick;

  tbase_clear_detect #(
    .CTRL_W (CTRL_W),
    .CLR_HI (CLR_HI),
    .CLR_LO (CLR_LO)
  ) u_clr (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clr_hit (clr_hit)
  );

  tbase_phase_div #(
    .DIV (DIV)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .sync_clr (clr_hit),
    .tick     (tick)
  );

  tbase_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .sync_clr (clr_hit),
    .tick     (tick),
    .count    (count),
    .ovf_stb  (ovf_stb),
    .tap_stb  (tap_stb)
  );
endmodule

// File: rtl/subclk_timebase_chk.sv
module subclk_timebase_chk #(
  parameter int unsigned CNT_W = tbase_pkg::DEF_CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             clr_hit,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic             ovf_stb,
  input logic [CNT_W-1:0] tap_stb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> (count == $past(count) || count == $past(count) + ONE));

  p_ovf_zero_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_stb |-> (count == '0));

  p_ovf_single_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_stb |=> !ovf_stb);

  p_tap_even_r4: assert property (@(posedge clk) disable iff (rst)
    (|tap_stb) |-> !count[0]);

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> (count == '0 && tap_stb == '0));

  p_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr_hit && !tick) |=> $stable(count));

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && tick) |=> !ovf_stb);
endmodule

bind subclk_timebase subclk_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .clr_hit (clr_hit),
  .tick    (tick),
  .count   (count),
  .ovf_stb (ovf_stb),
  .tap_stb (tap_stb)
);

// File: tb/subclk_timebase_tb.sv
module subclk_timebase_tb;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_data = 8'h00;
  logic [W-1:0] count;
  logic         ovf_stb;
  logic [W-1:0] tap_stb;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference state
  int unsigned m_cnt = 0;
  int unsigned m_div = 0;

  logic [2*W:0] exp_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  subclk_timebase u_dut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .count   (count),
    .ovf_stb (ovf_stb),
    .tap_stb (tap_stb)
  );

  // Driver: apply one cycle, advance the model, push the expectation
  task automatic step(input logic r, input logic w, input logic [7:0] d, input string tag);
    logic         e_ovf;
    logic [W-1:0] e_tap;
    bit           run;
    @(negedge clk);
    rst = r; wr_en = w; wr_data = d;
    @(posedge clk);
    e_ovf = 1'b0; e_tap = '0;
    if (r || (w && d[3] && d[2])) begin
      m_cnt = 0; m_div = 0;
    end else if (m_div == 3) begin
      run = 1'b1;
      for (int i = 0; i < W; i++) begin
        run = run && (((m_cnt >> i) & 1) == 1);
        e_tap[i] = run;
      end
      e_ovf = (m_cnt == 31);
      m_cnt = (m_cnt + 1) % 32;
      m_div = 0;
    end else begin
      m_div = m_div + 1;
    end
    exp_q.push_back({e_ovf, e_tap, W'(m_cnt)});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 8'h00, tag);
  endtask

  // Monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [2*W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if ({ovf_stb, tap_stb, count} !== e) begin
          n_fail++;
          $display("FAIL %s: got ovf=%0b tap=%b cnt=%0d expected ovf=%0b tap=%b cnt=%0d",
                   t, ovf_stb, tap_stb, count, e[2*W], e[2*W-1:W], e[W-1:0]);
        end
      end
    end
  end

  initial begin
    step(1'b1, 1'b0, 8'h00, "R1");
    step(1'b1, 1'b1, 8'hFF, "R1");
    step(1'b1, 1'b0, 8'h00, "R1");
    idle(12, "R2");
    // R6: partial or absent clear bits on every phase
    step(1'b0, 1'b1, 8'h04, "R6");
    step(1'b0, 1'b1, 8'h08, "R6");
    step(1'b0, 1'b1, 8'hF3, "R6");
    step(1'b0, 1'b1, 8'h00, "R6");
    step(1'b0, 1'b1, 8'hB7, "R6");
    idle(3, "R6");
    // R3 and R4: run through a complete wrap
    idle(140, "R3/R4");
    // R5: clear mid-interval, then exact four-edge step
    idle(2, "R5");
    step(1'b0, 1'b1, 8'h0C, "R5");
    idle(9, "R5");
    step(1'b0, 1'b1, 8'hFC, "R5");
    idle(6, "R5");
    // R7: clear on an advance edge
    while (m_div != 3) step(1'b0, 1'b0, 8'h00, "R7");
    step(1'b0, 1'b1, 8'h0C, "R7");
    idle(5, "R7");
    // R7: clear on the advance out of 31
    while (!(m_cnt == 31 && m_div == 3)) step(1'b0, 1'b0, 8'h00, "R7");
    step(1'b0, 1'b1, 8'h0C, "R7");
    idle(6, "R7");
    // R8: continuous run, 200 edges gives 50 advances
    begin
      int unsigned start;
      start = m_cnt;
      idle(200, "R8");
      n_run++;
      if (count !== W'((start + 50) % 32)) begin
        n_fail++;
        $display("FAIL R8: got cnt=%0d expected %0d", count, (start + 50) % 32);
      end
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule